// File: doc/BRIEF.md
# Smart-card character receive controller

This block sits behind an asynchronous serial receiver and decides what happens to each completed character. The bit sampler delivers a one-cycle strobe with the assembled data byte and its parity bit. In plain serial operation the byte goes into a one-entry receive buffer and a buffer-full flag is raised. Depending on a select bit, that flag requests either an interrupt or a DMA transfer.

With the smart-card protocol enabled and the character-level protocol (T=0) chosen, every character is first judged. Even parity is checked. While an initialization window is open, the byte must also be one of the two legal initial characters. A character that fails is never written to the buffer and is counted as a consecutive error. Depending on the configuration, it also makes the block request a NACK from the transmit-side driver. When the error run grows past a programmable threshold, a sticky flag is set. A character that passes while the buffer is still full is dropped and sets an overrun flag. In smart-card mode it can also request a NACK.

The controller has three states. ST_IDLE waits for a strobe; a strobe moves it to ST_JUDGE and captures the character. ST_JUDGE commits the decision in one cycle. It goes to ST_NACK if a NACK is needed and otherwise back to ST_IDLE. ST_NACK drives the NACK request for one cycle and always returns to ST_IDLE. Strobes that arrive outside ST_IDLE are not taken.

Top module: `sc_rx_char_ctrl`

## Requirements
- R1: Outside T=0 checking, a character strobed at clock edge N with the buffer empty appears on rx_data, with rx_full high, after edge N+1.
- R2: irq is high when (rx_full and cfg_rx_ie and not cfg_dma_sel) or (thr_flag and cfg_thr_ie). dma_req equals rx_full and cfg_dma_sel.
- R3: A data_rd pulse clears rx_full. If data_rd is high in the judging cycle, the buffer counts as empty for that character.
- R4: With cfg_iso_en=1 and cfg_t0=1, a character fails parity when the ones in its eight data bits plus the parity bit number odd. Such a character leaves rx_data and rx_full unchanged. When cfg_auto_nack=1 it raises nack_req for exactly the one cycle after edge N+1. With cfg_auto_nack=0 no NACK is requested.
- R5: An init_arm pulse sets init_active. In T=0 checking with init_active high, a character with good parity other than 0x3B or 0x03 is not stored and always requests a NACK. A character equal to one of those two values clears init_active.
- R6: In T=0 checking, err_count rises by one on each parity or initial-character failure, saturating at its maximum. It returns to zero on any character that passes both checks.
- R7: thr_flag is set when an increment makes err_count greater than cfg_err_thresh. It stays set until a clr_thr pulse.
- R8: A passing character that meets a full buffer is discarded and sets ovr_flag, which clr_ovr clears. It requests a NACK only when cfg_iso_en=1 and cfg_ovr_nack=1.
- R9: A character that fails a check while the buffer is full does not set ovr_flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| frame_valid | input | 1 | One-cycle strobe for a completed character |
| frame_data | input | DW | Received data byte |
| frame_par | input | 1 | Received parity bit |
| cfg_iso_en | input | 1 | Smart-card protocol enable |
| cfg_t0 | input | 1 | Character-level protocol selected |
| cfg_auto_nack | input | 1 | NACK on parity failure |
| cfg_ovr_nack | input | 1 | NACK on overrun |
| cfg_rx_ie | input | 1 | Buffer-full interrupt enable |
| cfg_dma_sel | input | 1 | Route buffer-full to DMA |
| cfg_thr_ie | input | 1 | Threshold interrupt enable |
| cfg_err_thresh | input | CNT_W | Consecutive-error threshold |
| init_arm | input | 1 | Open the initial-character window |
| data_rd | input | 1 | Data read strobe |
| clr_ovr | input | 1 | Clear overrun flag |
| clr_thr | input | 1 | Clear threshold flag |
| rx_data | output | DW | Receive buffer contents |
| rx_full | output | 1 | Buffer-full flag |
| ovr_flag | output | 1 | Overrun flag |
| thr_flag | output | 1 | Error-threshold flag |
| init_active | output | 1 | Initial-character window open |
| err_count | output | CNT_W | Consecutive error count |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |
| nack_req | output | 1 | One-cycle NACK request |

## Verification
Two events can share the judging edge: a data register read and the commit of the next character. The bench provokes this by raising data_rd in the judging cycle of some frames across the sweeps. The expected result is that the new byte is stored, rx_full stays high and no overrun or overrun NACK appears. A second collision, between a failing character and a full buffer, is judged by checking that only the error path fires and ovr_flag is untouched.

// File: rtl/sc_rx_pkg.sv
package sc_rx_pkg;
    localparam int DATA_W = 8;
    localparam logic [7:0] TS_DIRECT  = 8'h3B;
    localparam logic [7:0] TS_INVERSE = 8'h03;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_JUDGE = 2'd1,
        ST_NACK  = 2'd2
    } rx_state_e;

    typedef struct packed {
        logic par_bad;
        logic init_bad;
    } chk_res_t;
endpackage

// File: rtl/sc_rx_check.sv
module sc_rx_check #(
    parameter int DW = sc_rx_pkg::DATA_W
) (
    input  logic          t0_chk,
    input  logic          init_open,
    input  logic [DW-1:0] data,
    input  logic          par,
    output sc_rx_pkg::chk_res_t res
);
    import sc_rx_pkg::*;

    logic odd_ones;
    logic ts_match;

    always_comb begin
        odd_ones = ^{data, par};
        ts_match = (data[7:0] == TS_DIRECT) || (data[7:0] == TS_INVERSE);
        if (DW > 8) begin
            ts_match = ts_match && (data >> 8) == '0;
        end
        res.par_bad  = t0_chk && odd_ones;
        res.init_bad = t0_chk && init_open && !odd_ones && !ts_match;
    end
endmodule

// File: rtl/sc_rx_errcnt.sv
module sc_rx_errcnt #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             err_inc,
    input  logic             err_clr,
    input  logic             thr_clr,
    input  logic [CNT_W-1:0] thresh,
    output logic [CNT_W-1:0] count,
    output logic             thr_flag
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_next;
    logic             thr_hit;

    always_comb begin
        cnt_next = count;
        if (err_inc && count != CNT_MAX) begin
            cnt_next = count + 1'b1;
        end else if (err_clr) begin
            cnt_next = '0;
        end
        thr_hit = err_inc && (cnt_next > thresh);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count    <= '0;
            thr_flag <= 1'b0;
        end else begin
            count <= cnt_next;
            if (thr_hit) begin
                thr_flag <= 1'b1;
            end else if (thr_clr) begin
                thr_flag <= 1'b0;
            end
        end
    end

    p_thr_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_flag && !thr_clr) |=> thr_flag);
    p_cnt_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && !err_inc) |=> (count == '0));
endmodule

// File: rtl/sc_rx_buf.sv
module sc_rx_buf #(
    parameter int DW = sc_rx_pkg::DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic          rd,
    input  logic          ovr_set,
    input  logic          ovr_clr,
    output logic [DW-1:0] data,
    output logic          full,
    output logic          ovr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data <= '0;
            full <= 1'b0;
            ovr  <= 1'b0;
        end else begin
            if (wr) begin
                data <= wdata;
                full <= 1'b1;
            end else if (rd) begin
                full <= 1'b0;
            end
            if (ovr_set) begin
                ovr <= 1'b1;
            end else if (ovr_clr) begin
                ovr <= 1'b0;
            end
        end
    end

    p_full_after_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (full && data == $past(wdata)));
    p_ovr_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_set |=> ovr);
endmodule

// File: rtl/sc_rx_char_ctrl.sv
module sc_rx_char_ctrl #(
    parameter int DW    = sc_rx_pkg::DATA_W,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_valid,
    input  logic [DW-1:0]    frame_data,
    input  logic             frame_par,
    input  logic             cfg_iso_en,
    input  logic             cfg_t0,
    input  logic             cfg_auto_nack,
    input  logic             cfg_ovr_nack,
    input  logic             cfg_rx_ie,
    input  logic             cfg_dma_sel,
    input  logic             cfg_thr_ie,
    input  logic [CNT_W-1:0] cfg_err_thresh,
    input  logic             init_arm,
    input  logic             data_rd,
    input  logic             clr_ovr,
    input  logic             clr_thr,
    output logic [DW-1:0]    rx_data,
    output logic             rx_full,
    output logic             ovr_flag,
    output logic             thr_flag,
    output logic             init_active,
    output logic [CNT_W-1:0] err_count,
    output logic             irq,
    output logic             dma_req,
    output logic             nack_req
);
    import sc_rx_pkg::*;

    rx_state_e state_q, state_d;
    logic [DW-1:0] hold_data;
    logic          hold_par;
    chk_res_t      chk;
    logic          judging, t0_chk, char_err, char_ok;
    logic          full_eff, buf_wr, ovr_hit, need_nack;

    assign judging = (state_q == ST_JUDGE);
    assign t0_chk  = cfg_iso_en && cfg_t0;

    sc_rx_check #(.DW(DW)) u_check (
        .t0_chk    (t0_chk),
        .init_open (init_active),
        .data      (hold_data),
        .par       (hold_par),
        .res       (chk)
    );

    always_comb begin
        char_err  = judging && (chk.par_bad || chk.init_bad);
        char_ok   = judging && !(chk.par_bad || chk.init_bad);
        full_eff  = rx_full && !data_rd;
        buf_wr    = char_ok && !full_eff;
        ovr_hit   = char_ok && full_eff;
        need_nack = (chk.par_bad && cfg_auto_nack) || chk.init_bad
                  || (ovr_hit && cfg_iso_en && cfg_ovr_nack);
    end

    sc_rx_buf #(.DW(DW)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (buf_wr),
        .wdata   (hold_data),
        .rd      (data_rd),
        .ovr_set (ovr_hit),
        .ovr_clr (clr_ovr),
        .data    (rx_data),
        .full    (rx_full),
        .ovr     (ovr_flag)
    );

    sc_rx_errcnt #(.CNT_W(CNT_W)) u_errcnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .err_inc  (char_err),
        .err_clr  (char_ok && t0_chk),
        .thr_clr  (clr_thr),
        .thresh   (cfg_err_thresh),
        .count    (err_count),
        .thr_flag (thr_flag)
    );

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (frame_valid) state_d = ST_JUDGE;
            ST_JUDGE: state_d = need_nack ? ST_NACK : ST_IDLE;
            ST_NACK:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register, capture and initial-character window
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            hold_data   <= '0;
            hold_par    <= 1'b0;
            init_active <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && frame_valid) begin
                hold_data <= frame_data;
                hold_par  <= frame_par;
            end
            if (init_arm) begin
                init_active <= 1'b1;
            end else if (char_ok && t0_chk) begin
                init_active <= 1'b0;
            end
        end
    end

    // outputs
    always_comb begin
        nack_req = (state_q == ST_NACK);
        irq      = (rx_full && cfg_rx_ie && !cfg_dma_sel) || (thr_flag && cfg_thr_ie);
        dma_req  = rx_full && cfg_dma_sel;
    end

    p_nack_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        nack_req |=> !nack_req);
    p_err_no_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
        char_err |=> $stable(rx_data));
    p_no_ovr_on_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (char_err && !ovr_flag && !clr_ovr) |=> !ovr_flag);
    p_dma_masks_rx_irq_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_dma_sel && !(thr_flag && cfg_thr_ie)) |-> !irq);
endmodule

// File: tb/tb_sc_rx_char_ctrl.sv
module tb_sc_rx_char_ctrl;
    localparam int DW = 8;
    localparam int CW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_valid = 0, frame_par = 0;
    logic [DW-1:0] frame_data = '0;
    logic cfg_iso_en = 0, cfg_t0 = 0, cfg_auto_nack = 0, cfg_ovr_nack = 0;
    logic cfg_rx_ie = 0, cfg_dma_sel = 0, cfg_thr_ie = 0;
    logic [CW-1:0] cfg_err_thresh = '0;
    logic init_arm = 0, data_rd = 0, clr_ovr = 0, clr_thr = 0;
    logic [DW-1:0] rx_data;
    logic rx_full, ovr_flag, thr_flag, init_active, irq, dma_req, nack_req;
    logic [CW-1:0] err_count;

    int n_chk = 0, n_bad = 0;

    // bench model state
    logic m_full = 0, m_ovr = 0, m_thr = 0, m_init = 0;
    logic [DW-1:0] m_data = '0;
    int m_cnt = 0;

    always #2 clk = ~clk;

    sc_rx_char_ctrl #(.DW(DW), .CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .frame_data(frame_data),
        .frame_par(frame_par), .cfg_iso_en(cfg_iso_en), .cfg_t0(cfg_t0),
        .cfg_auto_nack(cfg_auto_nack), .cfg_ovr_nack(cfg_ovr_nack), .cfg_rx_ie(cfg_rx_ie),
        .cfg_dma_sel(cfg_dma_sel), .cfg_thr_ie(cfg_thr_ie), .cfg_err_thresh(cfg_err_thresh),
        .init_arm(init_arm), .data_rd(data_rd), .clr_ovr(clr_ovr), .clr_thr(clr_thr),
        .rx_data(rx_data), .rx_full(rx_full), .ovr_flag(ovr_flag), .thr_flag(thr_flag),
        .init_active(init_active), .err_count(err_count), .irq(irq), .dma_req(dma_req),
        .nack_req(nack_req)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic check_outputs();
        chk("R1", "rx_full", int'(rx_full), int'(m_full));
        if (m_full) chk("R1", "rx_data", int'(rx_data), int'(m_data));
        chk("R8", "ovr_flag", int'(ovr_flag), int'(m_ovr));
        chk("R6", "err_count", int'(err_count), m_cnt);
        chk("R7", "thr_flag", int'(thr_flag), int'(m_thr));
        chk("R5", "init_active", int'(init_active), int'(m_init));
        chk("R2", "irq", int'(irq),
            int'((m_full && cfg_rx_ie && !cfg_dma_sel) || (m_thr && cfg_thr_ie)));
        chk("R2", "dma_req", int'(dma_req), int'(m_full && cfg_dma_sel));
    endtask

    task automatic do_read();
        @(negedge clk); data_rd = 1;
        @(negedge clk); data_rd = 0;
        m_full = 0;
        chk("R3", "rx_full after read", int'(rx_full), 0);
    endtask

    task automatic do_clr_ovr();
        @(negedge clk); clr_ovr = 1;
        @(negedge clk); clr_ovr = 0;
        m_ovr = 0;
        chk("R8", "ovr_flag after clear", int'(ovr_flag), 0);
    endtask

    task automatic do_clr_thr();
        @(negedge clk); clr_thr = 1;
        @(negedge clk); clr_thr = 0;
        m_thr = 0;
        chk("R7", "thr_flag after clear", int'(thr_flag), 0);
    endtask

    task automatic do_arm();
        @(negedge clk); init_arm = 1;
        @(negedge clk); init_arm = 0;
        m_init = 1;
        chk("R5", "init_active after arm", int'(init_active), 1);
    endtask

    task automatic send(input logic [DW-1:0] d, input logic p, input logic rd_judge);
        logic t0c, pbad, ibad, err, full_eff, exp_nack, full_before;
        int nack1, nack2;
        t0c  = cfg_iso_en && cfg_t0;
        pbad = t0c && ((^d) ^ p);
        ibad = t0c && m_init && !pbad && !(d == 8'h3B || d == 8'h03);
        err  = pbad || ibad;
        full_before = m_full;
        full_eff = m_full && !rd_judge;
        exp_nack = (pbad && cfg_auto_nack) || ibad
                 || (!err && full_eff && cfg_iso_en && cfg_ovr_nack);
        if (rd_judge) m_full = 0;
        if (err) begin
            if (m_cnt < (1 << CW) - 1) m_cnt++;
            if (m_cnt > int'(cfg_err_thresh)) m_thr = 1;
        end else begin
            if (t0c) begin
                m_cnt = 0;
                m_init = 0;
            end
            if (full_eff) m_ovr = 1;
            else begin
                m_full = 1;
                m_data = d;
            end
        end
        @(negedge clk); frame_valid = 1; frame_data = d; frame_par = p;
        @(negedge clk); frame_valid = 0; data_rd = rd_judge;
        @(negedge clk); data_rd = 0; nack1 = int'(nack_req);
        @(negedge clk); nack2 = int'(nack_req);
        chk(pbad ? "R4" : (ibad ? "R5" : "R8"), "nack pulse", nack1, int'(exp_nack));
        chk("R4", "nack ends after one cycle", nack2, 0);
        if (err && full_before && !rd_judge)
            chk("R9", "no overrun on failed char", int'(ovr_flag), int'(m_ovr));
        if (!err && rd_judge && full_before)
            chk("R3", "read at decision keeps new char", int'(rx_full), 1);
        check_outputs();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check_outputs();
        chk("R4", "nack at reset", int'(nack_req), 0);

        // plain serial sweep: every byte, reads and clears interleaved
        cfg_rx_ie = 1; cfg_ovr_nack = 1; cfg_thr_ie = 1;
        for (int d = 0; d < 256; d++) begin
            cfg_dma_sel = d[3];
            if (d % 3 == 0) do_read();
            if (d % 7 == 0) do_clr_ovr();
            send(DW'(d), d[0], (d % 5 == 0));
        end

        // smart-card block protocol: no parity check, overrun NACK active
        do_read(); do_clr_ovr();
        cfg_iso_en = 1; cfg_t0 = 0;
        for (int d = 0; d < 32; d++) begin
            if (d % 2 == 0) do_read();
            send(DW'(d * 7), d[1], (d % 6 == 1));
        end

        // character protocol: all data/parity combinations
        do_read(); do_clr_ovr();
        cfg_t0 = 1; cfg_auto_nack = 1; cfg_err_thresh = 4'd2; cfg_dma_sel = 0;
        for (int v = 0; v < 512; v++) begin
            if (v % 2 == 0) do_read();
            if (v % 16 == 15) do_clr_thr();
            if (v % 11 == 0) do_clr_ovr();
            send(DW'(v), v[8] ^ v[4], (v % 9 == 4));
        end

        // parity failures without auto-NACK, saturating the counter
        do_read();
        cfg_auto_nack = 0; cfg_err_thresh = 4'd12;
        for (int k = 0; k < 20; k++) begin
            send(DW'(k + 40), ~(^DW'(k + 40)), 1'b0);
        end
        send(8'h55, ^8'h55, 1'b0);

        // initial-character window: every byte with good parity
        cfg_auto_nack = 1; cfg_err_thresh = 4'd15;
        do_clr_thr();
        for (int d = 0; d < 256; d++) begin
            do_read();
            do_arm();
            send(DW'(d), ^DW'(d), 1'b0);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule